// File: doc/BRIEF.md
# Shared SIMD and Floating-Point Register File

This block stores eight 80-bit physical registers that two execution units use at once. The floating-point unit reads and writes every bit of an entry. The packed-integer SIMD unit sees only the low 64 bits of each entry. Both units address the same storage, so a value written through one view can be read through the other.

The block also keeps the 16-bit tag word and the 3-bit top-of-stack field of the floating-point status word. It applies the bookkeeping that SIMD activity requires. Any SIMD operation marks every register valid and resets the top of stack. The clear-state operation marks every register empty instead. A SIMD write also sets the upper 16 bits of its entry, which hold the exponent field, to all ones.

The floating-point unit can load the top-of-stack field when no SIMD activity happens in that cycle. Both read ports are combinational from the storage.

Top module: `shared_simd_fp_rf`

## Requirements
- R1: After reset, every entry reads 0 on both views, the tag word is 16'hFFFF and the top of stack is 3'b000.
- R2: A SIMD write of value D to index n makes entry n read {16'hFFFF, D} on the 80-bit view from the next cycle on.
- R3: A floating-point write of value V to index n makes entry n read V on the 80-bit view and V[63:0] on the SIMD view from the next cycle on.
- R4: SIMD index n always selects physical entry n, whatever the current top of stack is.
- R5: A cycle with simdOp high or simdWrEn high, and clearOp low, sets the tag word to 16'h0000 (every 2-bit tag is 00, valid) on the next cycle.
- R6: A cycle with clearOp high sets the tag word to 16'hFFFF (every 2-bit tag is 11, empty) on the next cycle, even when simdOp or simdWrEn is also high.
- R7: A cycle with simdOp, simdWrEn or clearOp high sets the top of stack to 3'b000 on the next cycle, and a top-of-stack load in that cycle is ignored.
- R8: A cycle with topLoad high and no SIMD activity sets the top of stack to topLoadValue on the next cycle. With no load and no SIMD activity, the top of stack keeps its value.
- R9: When both write ports target the same index in one cycle, the SIMD write wins and the entry holds {16'hFFFF, simdWrData}.
- R10: When the two write ports target different indices in one cycle, both entries are written.
- R11: A floating-point write alone leaves the tag word and the top of stack unchanged.
- R12: A write is not visible on either read port in the cycle it is presented. It becomes visible after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| simdWrEn | input | 1 | SIMD register write enable (counts as a SIMD operation) |
| simdWrIdx | input | 3 | SIMD register index to write |
| simdWrData | input | 64 | SIMD write value |
| fpWrEn | input | 1 | Floating-point register write enable |
| fpWrIdx | input | 3 | Physical entry to write through the 80-bit view |
| fpWrData | input | 80 | Floating-point write value |
| simdOp | input | 1 | A SIMD operation other than clear-state executes this cycle |
| clearOp | input | 1 | The clear-state operation executes this cycle |
| topLoad | input | 1 | Floating-point unit loads the top-of-stack field |
| topLoadValue | input | 3 | New top-of-stack value |
| simdRdIdx | input | 3 | SIMD read index |
| simdRdData | output | 64 | Low 64 bits of the selected entry |
| fpRdIdx | input | 3 | Floating-point read index |
| fpRdData | output | 80 | Full selected entry |
| tagWord | output | 16 | Tag word, tag i in bits 2i+1:2i |
| stackTop | output | 3 | Top-of-stack field (status word bits 13:11) |

## Verification
On every cycle, assertions check how the strobes drive the tag word and the top of stack. They check the all-valid and all-empty results, the clearing of the top of stack, and that both hold their values when no strobe is active. They also check that a SIMD write leaves ones in the exponent bits of its entry. Only the bench scenarios can show the data that comes back through the two views. These scenarios cover cross-view reads, the mapping that ignores the top of stack, a same-index write collision, and a write that stays invisible until the clock edge.

// File: rtl/sfrf_pkg.sv
package sfrf_pkg;

  // Strobes the control half hands to the datapath each cycle
  typedef struct packed {
    logic simdWr;    // write low half, force exponent bits to ones
    logic fpWr;      // write full entry
    logic tagValid;  // mark every tag 00
    logic tagEmpty;  // mark every tag 11
    logic topClear;  // force top of stack to zero
    logic topLoad;   // accept the floating-point top-of-stack value
  } sfrfStrobesT;

endpackage

// File: rtl/sfrf_ctrl.sv
module sfrf_ctrl
  import sfrf_pkg::*;
(
  input  logic        simdWrEn,
  input  logic        fpWrEn,
  input  logic        simdOp,
  input  logic        clearOp,
  input  logic        topLoad,
  output sfrfStrobesT strobes
);

  logic anySimd;

  // A SIMD write is itself a SIMD operation
  assign anySimd = simdOp | simdWrEn | clearOp;

  always_comb begin
    strobes          = '0;
    strobes.simdWr   = simdWrEn;
    strobes.fpWr     = fpWrEn;
    strobes.tagEmpty = clearOp;
    strobes.tagValid = (simdOp | simdWrEn) & ~clearOp;
    strobes.topClear = anySimd;
    strobes.topLoad  = topLoad & ~anySimd;
  end

endmodule

// File: rtl/sfrf_datapath.sv
module sfrf_datapath
  import sfrf_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int SIMD_W   = 64,
  parameter int FP_W     = 80,
  parameter int TAG_W    = 2,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sfrfStrobesT               strobes,
  input  logic [IDX_W-1:0]          simdWrIdx,
  input  logic [SIMD_W-1:0]         simdWrData,
  input  logic [IDX_W-1:0]          fpWrIdx,
  input  logic [FP_W-1:0]           fpWrData,
  input  logic [IDX_W-1:0]          topValue,
  input  logic [IDX_W-1:0]          simdRdIdx,
  input  logic [IDX_W-1:0]          fpRdIdx,
  output logic [SIMD_W-1:0]         simdRdData,
  output logic [FP_W-1:0]           fpRdData,
  output logic [NUM_REGS*TAG_W-1:0] tagWord,
  output logic [IDX_W-1:0]          stackTop
);

  localparam int EXP_W     = FP_W - SIMD_W;
  localparam int TAGWORD_W = NUM_REGS * TAG_W;

  logic [FP_W-1:0]      entryBus [NUM_REGS];
  logic [TAGWORD_W-1:0] tagQ;
  logic [IDX_W-1:0]     topQ;

  // One storage entry per physical register; SIMD port has priority
  for (genvar g = 0; g < NUM_REGS; g++) begin : gEntry
    logic [FP_W-1:0] entryQ;
    logic            simdHit;
    logic            fpHit;

    assign simdHit = strobes.simdWr && (simdWrIdx == IDX_W'(g));
    assign fpHit   = strobes.fpWr && (fpWrIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryQ <= '0;
      end else if (simdHit) begin
        entryQ <= {{EXP_W{1'b1}}, simdWrData};
      end else if (fpHit) begin
        entryQ <= fpWrData;
      end
    end

    assign entryBus[g] = entryQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagQ <= '1;
    end else if (strobes.tagEmpty) begin
      tagQ <= '1;
    end else if (strobes.tagValid) begin
      tagQ <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topQ <= '0;
    end else if (strobes.topClear) begin
      topQ <= '0;
    end else if (strobes.topLoad) begin
      topQ <= topValue;
    end
  end

  assign fpRdData   = entryBus[fpRdIdx];
  assign simdRdData = entryBus[simdRdIdx][SIMD_W-1:0];
  assign tagWord    = tagQ;
  assign stackTop   = topQ;

  // R2: exponent bits of a SIMD-written entry read as ones afterwards
  assert_simd_exponent_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.simdWr |=> entryBus[$past(simdWrIdx)][FP_W-1:SIMD_W] == {EXP_W{1'b1}});

  assert_tags_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tagValid |=> tagWord == '0);

  assert_tags_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tagEmpty |=> tagWord == '1);

  assert_top_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.topClear |=> stackTop == '0);

  assert_top_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.topClear && !strobes.topLoad) |=> $stable(stackTop));

  assert_tags_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.tagValid && !strobes.tagEmpty) |=> $stable(tagWord));

endmodule

// File: rtl/shared_simd_fp_rf.sv
module shared_simd_fp_rf
  import sfrf_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int SIMD_W   = 64,
  parameter int FP_W     = 80,
  parameter int TAG_W    = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      simdWrEn,
  input  logic [IDX_W-1:0]          simdWrIdx,
  input  logic [SIMD_W-1:0]         simdWrData,
  input  logic                      fpWrEn,
  input  logic [IDX_W-1:0]          fpWrIdx,
  input  logic [FP_W-1:0]           fpWrData,
  input  logic                      simdOp,
  input  logic                      clearOp,
  input  logic                      topLoad,
  input  logic [IDX_W-1:0]          topLoadValue,
  input  logic [IDX_W-1:0]          simdRdIdx,
  output logic [SIMD_W-1:0]         simdRdData,
  input  logic [IDX_W-1:0]          fpRdIdx,
  output logic [FP_W-1:0]           fpRdData,
  output logic [NUM_REGS*TAG_W-1:0] tagWord,
  output logic [IDX_W-1:0]          stackTop
);

  sfrfStrobesT strobes;

  sfrf_ctrl u_ctrl (
    .simdWrEn (simdWrEn),
    .fpWrEn   (fpWrEn),
    .simdOp   (simdOp),
    .clearOp  (clearOp),
    .topLoad  (topLoad),
    .strobes  (strobes)
  );

  sfrf_datapath #(
    .NUM_REGS (NUM_REGS),
    .SIMD_W   (SIMD_W),
    .FP_W     (FP_W),
    .TAG_W    (TAG_W),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .simdWrIdx  (simdWrIdx),
    .simdWrData (simdWrData),
    .fpWrIdx    (fpWrIdx),
    .fpWrData   (fpWrData),
    .topValue   (topLoadValue),
    .simdRdIdx  (simdRdIdx),
    .fpRdIdx    (fpRdIdx),
    .simdRdData (simdRdData),
    .fpRdData   (fpRdData),
    .tagWord    (tagWord),
    .stackTop   (stackTop)
  );

endmodule

// File: tb/shared_simd_fp_rf_tb.sv
`timescale 1ns/1ps
module shared_simd_fp_rf_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        simdWrEn;
  logic [2:0]  simdWrIdx;
  logic [63:0] simdWrData;
  logic        fpWrEn;
  logic [2:0]  fpWrIdx;
  logic [79:0] fpWrData;
  logic        simdOp;
  logic        clearOp;
  logic        topLoad;
  logic [2:0]  topLoadValue;
  logic [2:0]  simdRdIdx;
  logic [63:0] simdRdData;
  logic [2:0]  fpRdIdx;
  logic [79:0] fpRdData;
  logic [15:0] tagWord;
  logic [2:0]  stackTop;

  int checks   = 0;
  int failures = 0;

  always #10 clk = ~clk;

  shared_simd_fp_rf u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .simdWrEn     (simdWrEn),
    .simdWrIdx    (simdWrIdx),
    .simdWrData   (simdWrData),
    .fpWrEn       (fpWrEn),
    .fpWrIdx      (fpWrIdx),
    .fpWrData     (fpWrData),
    .simdOp       (simdOp),
    .clearOp      (clearOp),
    .topLoad      (topLoad),
    .topLoadValue (topLoadValue),
    .simdRdIdx    (simdRdIdx),
    .simdRdData   (simdRdData),
    .fpRdIdx      (fpRdIdx),
    .fpRdData     (fpRdData),
    .tagWord      (tagWord),
    .stackTop     (stackTop)
  );

  // Control vectors: strobes for one cycle, expected tag word and top after the edge
  typedef struct packed {
    logic        vSimdOp;
    logic        vClear;
    logic        vLoad;
    logic [2:0]  vLoadVal;
    logic        vSimdWr;
    logic        vFpWr;
    logic [15:0] expTag;
    logic [2:0]  expTop;
  } vecT;

  localparam int NUM_VEC = 9;
  localparam vecT VEC [NUM_VEC] = '{
    '{1'b0, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0, 16'hFFFF, 3'd5},  // R8 load
    '{1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 16'hFFFF, 3'd5},  // R11 fp write only
    '{1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0000, 3'd0},  // R5 R7 simd op
    '{1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 16'h0000, 3'd3},  // R8 load
    '{1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 16'hFFFF, 3'd0},  // R6 R7 clear
    '{1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 16'h0000, 3'd0},  // R5 simd write
    '{1'b1, 1'b0, 1'b1, 3'd6, 1'b0, 1'b0, 16'h0000, 3'd0},  // R7 load ignored
    '{1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 16'hFFFF, 3'd0},  // R6 clear wins
    '{1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b1, 16'hFFFF, 3'd2}   // R8 R11
  };

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    simdWrEn = 0; simdWrIdx = 0; simdWrData = '0;
    fpWrEn = 0; fpWrIdx = 0; fpWrData = '0;
    simdOp = 0; clearOp = 0; topLoad = 0; topLoadValue = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 0;
    idle();
    simdRdIdx = 3'd3;
    fpRdIdx   = 3'd3;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 tag", 80'(tagWord), 80'hFFFF);
    check("R1 top", 80'(stackTop), 80'h0);
    check("R1 fp read", fpRdData, 80'h0);
    check("R1 simd read", 80'(simdRdData), 80'h0);

    // Control vector walk
    for (int i = 0; i < NUM_VEC; i++) begin
      idle();
      simdOp       = VEC[i].vSimdOp;
      clearOp      = VEC[i].vClear;
      topLoad      = VEC[i].vLoad;
      topLoadValue = VEC[i].vLoadVal;
      simdWrEn     = VEC[i].vSimdWr;
      simdWrIdx    = 3'd0;
      fpWrEn       = VEC[i].vFpWr;
      fpWrIdx      = 3'd7;
      fpWrData     = 80'h4000_8000_0000_0000_0000;
      @(negedge clk);
      check("R5/R6/R11 tag vector", 80'(tagWord), 80'(VEC[i].expTag));
      check("R7/R8 top vector", 80'(stackTop), 80'(VEC[i].expTop));
    end
    idle();

    // R3 and R12: full write via the 80-bit view
    fpRdIdx = 3'd4; simdRdIdx = 3'd4;
    fpWrEn = 1; fpWrIdx = 3'd4; fpWrData = 80'h1234_89AB_CDEF_0123_4567;
    #1;
    check("R12 not yet visible", fpRdData, 80'h0);
    @(negedge clk);
    idle();
    check("R3 fp view", fpRdData, 80'h1234_89AB_CDEF_0123_4567);
    check("R3 simd view", 80'(simdRdData), 80'h89AB_CDEF_0123_4567);

    // R2: SIMD write forces exponent bits
    simdWrEn = 1; simdWrIdx = 3'd4; simdWrData = 64'h0BAD_F00D_1357_2468;
    @(negedge clk);
    idle();
    check("R2 fp view of simd write", fpRdData, 80'hFFFF_0BAD_F00D_1357_2468);

    // R4: SIMD index ignores top of stack
    fpWrEn = 1; fpWrIdx = 3'd2; fpWrData = 80'h7777_0000_1111_2222_3333;
    @(negedge clk);
    idle();
    topLoad = 1; topLoadValue = 3'd5;
    @(negedge clk);
    idle();
    simdRdIdx = 3'd2;
    #1;
    check("R4 top loaded", 80'(stackTop), 80'd5);
    check("R4 simd index 2", 80'(simdRdData), 80'h0000_1111_2222_3333);

    // R9: collision on the same index
    simdWrEn = 1; simdWrIdx = 3'd6; simdWrData = 64'hAAAA_BBBB_CCCC_DDDD;
    fpWrEn = 1; fpWrIdx = 3'd6; fpWrData = 80'h1111_2222_3333_4444_5555;
    @(negedge clk);
    idle();
    fpRdIdx = 3'd6;
    #1;
    check("R9 simd wins", fpRdData, 80'hFFFF_AAAA_BBBB_CCCC_DDDD);

    // R10: both ports to different indices
    simdWrEn = 1; simdWrIdx = 3'd1; simdWrData = 64'h0101_0202_0303_0404;
    fpWrEn = 1; fpWrIdx = 3'd3; fpWrData = 80'h3C00_5050_6060_7070_8080;
    @(negedge clk);
    idle();
    fpRdIdx = 3'd1; simdRdIdx = 3'd3;
    #1;
    check("R10 simd entry", fpRdData, 80'hFFFF_0101_0202_0303_0404);
    check("R10 fp entry", 80'(simdRdData), 80'h5050_6060_7070_8080);
    fpRdIdx = 3'd3;
    #1;
    check("R10 fp entry full", fpRdData, 80'h3C00_5050_6060_7070_8080);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule